// File: doc/BRIEF.md
# Dual-Cell FIR Output Combiner with Programmable Rounding

This block sits behind two FIR filter cells and merges their results into a single output word. In add mode it returns the sum of both cell results, which is what a 16-tap cascade, a complex filter or a quadrature pair needs. In select mode it forwards the result of one cell, chosen by a select bit. The merged value is rounded at a programmable bit position and registered once. It leaves the block as a 28-bit word split into a 9-bit low field and a 19-bit high field.

Each field has its own active-low output enable. The pad drivers are modelled as data plus a drive flag, so the data ports always carry the registered value. The 9-bit low field shares its pins with the low nine bits of the second cell's data input. The block therefore also produces the value that the second cell sees on those shared pins: its own low field while that field is driven, and the external source otherwise.

Top module: `fir_out_combiner`

## Requirements
- R1: With `sum_mode`=1, the registered result is the two's-complement sum `cell_a_res + cell_b_res`, and `pass_sel_b` has no effect.
- R2: With `sum_mode`=0, the registered result is `cell_a_res` when `pass_sel_b`=0 and `cell_b_res` when `pass_sel_b`=1, sign-extended.
- R3: For a rounding position p in 1..19, the value 2^(p-1) is added to the merged value and bits p-1..0 are then cleared (round half up toward plus infinity in two's complement). p=0 leaves the value unchanged.
- R4: `rnd_pos` values 20..31 behave exactly as position 19.
- R5: A result captured with `in_valid`=1 at a rising edge appears on the outputs after that same edge, and `out_valid` is 1 for exactly the cycles that follow an edge where `in_valid` was 1.
- R6: While `in_valid`=0 the output word keeps its last value, whatever the other inputs do.
- R7: Result bits 8..0 appear on `out_lo` and bits 27..9 on `out_hi`. For 26-bit inputs no combination of mode, operands and rounding wraps the 28-bit word.
- R8: `lo_drive` is the inverse of `oe_lo_n` and `hi_drive` is the inverse of `oe_hi_n`, with no clock delay. The two are independent, and neither enable changes the data on `out_lo` or `out_hi`.
- R9: `cellb_din[8:0]` equals `out_lo` while `lo_drive`=1 and equals `inb_ext[8:0]` otherwise. `cellb_din[9]` always equals `inb_ext[9]`.
- R10: Synchronous reset clears the output word to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Cell results are valid this cycle |
| cell_a_res | input | 26 | Signed result of cell A |
| cell_b_res | input | 26 | Signed result of cell B |
| sum_mode | input | 1 | 1: add both cells, 0: pass one cell |
| pass_sel_b | input | 1 | In pass mode, 1 selects cell B |
| rnd_pos | input | 5 | Rounding bit position, 0 disables |
| oe_lo_n | input | 1 | Active-low enable of the low field |
| oe_hi_n | input | 1 | Active-low enable of the high field |
| inb_ext | input | 10 | Value an external source places on the cell B input pins |
| out_valid | output | 1 | Output word was updated at the last edge |
| out_lo | output | 9 | Result bits 8..0 |
| out_hi | output | 19 | Result bits 27..9 |
| lo_drive | output | 1 | Low field pads are driving |
| hi_drive | output | 1 | High field pads are driving |
| cellb_din | output | 10 | Resolved value on the cell B data input pins |

## Verification
The bench sweeps every rounding code, including the clamped range above 19, across operand pairs that include zero, ±1, exact half-LSB ties, negative ties and both full-scale extremes, in all three merge modes. A rounder that truncated toward zero or rounded ties away from zero would miss the negative tie cases. A missing clamp would zero or garble the word for codes 20..31, and a narrow adder would wrap at full scale. The hold sweep changes every input while `in_valid` is low, which exposes a register that loads unconditionally. The pin sweep walks all four enable combinations against changing external values, which catches a swapped or inverted enable and a shared-pin mux that forwards the wrong source.

// File: rtl/foc_pkg.sv
package foc_pkg;

    // Default geometry of the combiner
    localparam int unsigned CELL_W_D  = 26;
    localparam int unsigned LO_W_D    = 9;
    localparam int unsigned HI_W_D    = 19;
    localparam int unsigned POS_W_D   = 5;
    localparam int unsigned MAX_POS_D = 19;

    // Merge path choice derived from the mode inputs
    typedef enum logic [1:0] {
        MERGE_PICK_A = 2'd0,
        MERGE_PICK_B = 2'd1,
        MERGE_ADD    = 2'd2
    } merge_e;

    // Pad control state for the two output fields
    typedef struct packed {
        logic lo_drive;
        logic hi_drive;
    } pad_ctl_t;

    function automatic merge_e decode_merge(input logic sum_mode, input logic sel_b);
        if (sum_mode)
            return MERGE_ADD;
        else if (sel_b)
            return MERGE_PICK_B;
        else
            return MERGE_PICK_A;
    endfunction

    function automatic int unsigned clamp_pos(input int unsigned pos, input int unsigned max_pos);
        return (pos > max_pos) ? max_pos : pos;
    endfunction

endpackage

// File: rtl/foc_merge.sv
module foc_merge
    import foc_pkg::*;
#(
    parameter int unsigned CELL_W = CELL_W_D,
    parameter int unsigned OUT_W  = LO_W_D + HI_W_D
) (
    input  logic signed [CELL_W-1:0] a_res,
    input  logic signed [CELL_W-1:0] b_res,
    input  merge_e                   how,
    output logic signed [OUT_W-1:0]  merged
);
    logic signed [OUT_W-1:0] a_ext;
    logic signed [OUT_W-1:0] b_ext;

    assign a_ext = OUT_W'(a_res);
    assign b_ext = OUT_W'(b_res);

    always_comb begin
        unique case (how)
            MERGE_ADD:    merged = a_ext + b_ext;
            MERGE_PICK_B: merged = b_ext;
            default:      merged = a_ext;
        endcase
    end
endmodule

// File: rtl/foc_round.sv
module foc_round
    import foc_pkg::*;
#(
    parameter int unsigned OUT_W   = LO_W_D + HI_W_D,
    parameter int unsigned POS_W   = POS_W_D,
    parameter int unsigned MAX_POS = MAX_POS_D
) (
    input  logic signed [OUT_W-1:0] din,
    input  logic [POS_W-1:0]        pos,
    output logic signed [OUT_W-1:0] dout
);
    logic signed [OUT_W-1:0] cand [0:MAX_POS];
    int unsigned             pos_eff;

    assign pos_eff = clamp_pos(int'(pos), MAX_POS);
    assign cand[0] = din;

    // One rounded candidate per legal position
    generate
        for (genvar k = 1; k <= MAX_POS; k++) begin : g_pos
            localparam logic [OUT_W-1:0] HALF = OUT_W'(1) << (k - 1);
            localparam logic [OUT_W-1:0] KEEP = ~((OUT_W'(1) << k) - OUT_W'(1));
            assign cand[k] = (din + HALF) & KEEP;
        end
    endgenerate

    assign dout = cand[pos_eff];

    // R3: rounding error lies in (-half, +half]
    always_comb begin
        if (!$isunknown({din, pos}) && pos_eff != 0) begin
            rnd_err_chk: assert ((OUT_W + 1)'(dout) - (OUT_W + 1)'(din) <= ((OUT_W + 1)'(1) << (pos_eff - 1))
                              && (OUT_W + 1)'(din) - (OUT_W + 1)'(dout) < ((OUT_W + 1)'(1) << (pos_eff - 1)));
        end
    end
endmodule

// File: rtl/foc_outreg.sv
module foc_outreg
    import foc_pkg::*;
#(
    parameter int unsigned OUT_W = LO_W_D + HI_W_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OUT_W-1:0] d,
    output logic [OUT_W-1:0] q,
    output logic             q_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load)
                q <= d;
        end
    end

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> q_valid);
    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> !q_valid);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q == '0 && !q_valid));
endmodule

// File: rtl/foc_pads.sv
module foc_pads
    import foc_pkg::*;
#(
    parameter int unsigned LO_W = LO_W_D,
    parameter int unsigned IN_W = 10
) (
    input  logic            oe_lo_n,
    input  logic            oe_hi_n,
    input  logic [LO_W-1:0] lo_field,
    input  logic [IN_W-1:0] ext_in,
    output pad_ctl_t        ctl,
    output logic [IN_W-1:0] shared_in
);
    assign ctl.lo_drive = ~oe_lo_n;
    assign ctl.hi_drive = ~oe_hi_n;

    // Shared pins resolve to whichever side is driving them
    generate
        for (genvar i = 0; i < IN_W; i++) begin : g_pin
            if (i < LO_W) begin : g_shared
                assign shared_in[i] = ctl.lo_drive ? lo_field[i] : ext_in[i];
            end else begin : g_private
                assign shared_in[i] = ext_in[i];
            end
        end
    endgenerate
endmodule

// File: rtl/fir_out_combiner.sv
module fir_out_combiner
    import foc_pkg::*;
#(
    parameter int unsigned CELL_W  = CELL_W_D,
    parameter int unsigned LO_W    = LO_W_D,
    parameter int unsigned HI_W    = HI_W_D,
    parameter int unsigned POS_W   = POS_W_D,
    parameter int unsigned MAX_POS = MAX_POS_D,
    parameter int unsigned IN_W    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CELL_W-1:0] cell_a_res,
    input  logic [CELL_W-1:0] cell_b_res,
    input  logic              sum_mode,
    input  logic              pass_sel_b,
    input  logic [POS_W-1:0]  rnd_pos,
    input  logic              oe_lo_n,
    input  logic              oe_hi_n,
    input  logic [IN_W-1:0]   inb_ext,
    output logic              out_valid,
    output logic [LO_W-1:0]   out_lo,
    output logic [HI_W-1:0]   out_hi,
    output logic              lo_drive,
    output logic              hi_drive,
    output logic [IN_W-1:0]   cellb_din
);
    localparam int unsigned OUT_W = LO_W + HI_W;

    merge_e                  how;
    logic signed [OUT_W-1:0] merged;
    logic signed [OUT_W-1:0] rounded;
    logic [OUT_W-1:0]        word_q;
    pad_ctl_t                pads;

    assign how = decode_merge(sum_mode, pass_sel_b);

    foc_merge #(.CELL_W(CELL_W), .OUT_W(OUT_W)) u_merge (
        .a_res  (cell_a_res),
        .b_res  (cell_b_res),
        .how    (how),
        .merged (merged)
    );

    foc_round #(.OUT_W(OUT_W), .POS_W(POS_W), .MAX_POS(MAX_POS)) u_round (
        .din  (merged),
        .pos  (rnd_pos),
        .dout (rounded)
    );

    foc_outreg #(.OUT_W(OUT_W)) u_outreg (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d       (rounded),
        .q       (word_q),
        .q_valid (out_valid)
    );

    assign out_lo = word_q[LO_W-1:0];
    assign out_hi = word_q[OUT_W-1:LO_W];

    foc_pads #(.LO_W(LO_W), .IN_W(IN_W)) u_pads (
        .oe_lo_n   (oe_lo_n),
        .oe_hi_n   (oe_hi_n),
        .lo_field  (word_q[LO_W-1:0]),
        .ext_in    (inb_ext),
        .ctl       (pads),
        .shared_in (cellb_din)
    );

    assign lo_drive = pads.lo_drive;
    assign hi_drive = pads.hi_drive;

    // Reference sum from the ports, used only by the checks below
    logic signed [OUT_W-1:0] chk_sum;
    assign chk_sum = OUT_W'($signed(cell_a_res)) + OUT_W'($signed(cell_b_res));

    // R1
    sum_path_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sum_mode && rnd_pos == '0) |=> ({out_hi, out_lo} == $past(chk_sum)));
    // R9
    shared_pin_chk: assert property (@(posedge clk) disable iff (rst)
        lo_drive |-> (cellb_din[LO_W-1:0] == out_lo));
    // R8
    drive_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_drive != oe_hi_n) && (lo_drive != oe_lo_n));
endmodule

// File: tb/fir_out_combiner_bench.sv
module fir_out_combiner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [25:0] cell_a_res, cell_b_res;
    logic        sum_mode, pass_sel_b;
    logic [4:0]  rnd_pos;
    logic        oe_lo_n, oe_hi_n;
    logic [9:0]  inb_ext;
    logic        out_valid;
    logic [8:0]  out_lo;
    logic [18:0] out_hi;
    logic        lo_drive, hi_drive;
    logic [9:0]  cellb_din;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fir_out_combiner u_fir_out_combiner (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .cell_a_res(cell_a_res), .cell_b_res(cell_b_res),
        .sum_mode(sum_mode), .pass_sel_b(pass_sel_b), .rnd_pos(rnd_pos),
        .oe_lo_n(oe_lo_n), .oe_hi_n(oe_hi_n), .inb_ext(inb_ext),
        .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi),
        .lo_drive(lo_drive), .hi_drive(hi_drive), .cellb_din(cellb_din)
    );

    longint vals [15] = '{0, 1, -1, 2, -2, 3, 511, -512, 262144, -262144,
                          33554431, -33554432, 1234567, -7654321, 524288};

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model(input longint a, input longint b, input bit sm,
                                     input bit sb, input int pos);
        longint v;
        int p;
        v = sm ? a + b : (sb ? b : a);
        p = (pos > 19) ? 19 : pos;
        if (p != 0)
            v = ((v + (longint'(1) << (p - 1))) >>> p) <<< p;
        return v & ((longint'(1) << 28) - 1);
    endfunction

    task automatic apply(input longint a, input longint b, input bit sm, input bit sb, input int pos);
        in_valid   = 1'b1;
        cell_a_res = 26'(a);
        cell_b_res = 26'(b);
        sum_mode   = sm;
        pass_sel_b = sb;
        rnd_pos    = 5'(pos);
    endtask

    task automatic run_one(input string req, input longint a, input longint b,
                           input bit sm, input bit sb, input int pos);
        @(negedge clk);
        apply(a, b, sm, sb, pos);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " value"}, longint'({out_hi, out_lo}), model(a, b, sm, sb, pos));
        check("R5 valid", longint'(out_valid), 1);
    endtask

    initial begin
        longint held;
        rst = 1'b1; in_valid = 1'b0; cell_a_res = '0; cell_b_res = '0;
        sum_mode = 1'b0; pass_sel_b = 1'b0; rnd_pos = '0;
        oe_lo_n = 1'b1; oe_hi_n = 1'b1; inb_ext = '0;
        repeat (3) @(negedge clk);
        // R10: state after reset
        check("R10 word", longint'({out_hi, out_lo}), 0);
        check("R10 valid", longint'(out_valid), 0);
        rst = 1'b0;

        // R1, R2, R3, R4, R7: sweep operands, modes and every rounding code
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 32; p++) begin
                for (int i = 0; i < 15; i++) begin
                    for (int j = 0; j < 15; j++) begin
                        if (m == 0)      run_one("R1 R3 R4 R7 sum",   vals[i], vals[j], 1'b1, 1'b0, p);
                        else if (m == 1) run_one("R1 sum sel_b",      vals[i], vals[j], 1'b1, 1'b1, p);
                        else if (m == 2) run_one("R2 R3 pass a",      vals[i], vals[j], 1'b0, 1'b0, p);
                        else             run_one("R2 R4 pass b",      vals[i], vals[j], 1'b0, 1'b1, p);
                    end
                end
            end
        end

        // R3: negative tie rounds toward plus infinity (-3 at p=1 -> -2)
        run_one("R3 neg tie", -3, 0, 1'b0, 1'b0, 1);
        check("R3 neg tie exact", longint'({out_hi, out_lo}), (longint'(1) << 28) - 2);

        // R5: a cycle without in_valid drops out_valid
        @(negedge clk);
        check("R5 idle valid", longint'(out_valid), 0);

        // R6: inputs change while in_valid is low, word must hold
        held = longint'({out_hi, out_lo});
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            cell_a_res = 26'(vals[k % 15]); cell_b_res = 26'(vals[(k + 3) % 15]);
            sum_mode = k[0]; pass_sel_b = k[1]; rnd_pos = 5'(k);
            @(negedge clk);
            check("R6 hold", longint'({out_hi, out_lo}), held);
        end

        // R8, R9: enables and shared pins, data stays on the ports
        run_one("R7 load", 12345, 0, 1'b0, 1'b0, 0);
        for (int e = 0; e < 4; e++) begin
            for (int x = 0; x < 8; x++) begin
                logic [9:0] ext;
                ext = 10'(x * 149 + 37);
                @(negedge clk);
                oe_lo_n = e[0]; oe_hi_n = e[1]; inb_ext = ext;
                #1;
                check("R8 lo_drive", longint'(lo_drive), longint'(!e[0]));
                check("R8 hi_drive", longint'(hi_drive), longint'(!e[1]));
                check("R8 data kept", longint'({out_hi, out_lo}), 12345);
                check("R9 cellb low", longint'(cellb_din[8:0]),
                      e[0] ? longint'(ext[8:0]) : longint'(12345 & 511));
                check("R9 cellb bit9", longint'(cellb_din[9]), longint'(ext[9]));
            end
        end

        // R10: reset mid-run clears the word
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 rerun word", longint'({out_hi, out_lo}), 0);
        check("R10 rerun valid", longint'(out_valid), 0);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule